// File: doc/BRIEF.md
# Octave Clock Divider

The block turns a fast master clock into a square-wave output by dividing it by a power of two. A 4-bit octave code selects the power. A higher code gives a faster output, and code 15 is the fastest range. The divided wave drives a main clock output and an auxiliary clock output. A 2-bit mode code sets which of the two runs. In one mode the auxiliary output is the inverse of the main output. In another mode the block sleeps with its counter held.

Software writes the octave and mode together through a one-cycle write strobe. The written value waits as a pending setting. While the block runs, the pending setting is adopted only at the end of a complete output period, so no shortened phase ever reaches a clock pin. While the block sleeps, a write is adopted at once.

An output-enable input pulls both pins low through gating logic alone, with no clock edge involved. It does not disturb the divider, so the wave continues in phase when the enable returns.

Top module: `octave_clock_divider`

## Requirements
- R1: With octave code k (0..15), a running output has a period of 2^(16−k) master cycles. This is a half-rate reference divided by 2^(15−k), so code 15 gives a period of 2 and code 0 a period of 65536.
- R2: A running output is high for exactly half of its period and low for the other half.
- R3: Mode code 2'b00 runs both outputs, with the auxiliary output always the inverse of the main output.
- R4: Mode code 2'b01 holds the main output low and runs the auxiliary output at the selected rate.
- R5: Mode code 2'b10 runs the main output and holds the auxiliary output low.
- R6: Mode code 2'b11 sleeps: both outputs stay low and the counter is held at zero. A write made during sleep is adopted on the next cycle, and the divider then restarts from zero. The main output first rises 10 cycles after the write cycle when the new code is 12.
- R7: When out_en is low, both outputs are low at once, without waiting for a clock edge. Raising out_en again restores the outputs immediately, with the period unchanged.
- R8: During and after reset the setting is octave 0 with mode 2'b00. The main output starts low and the auxiliary output starts high. The first low phase of the main output after reset release lasts 2^15 cycles.
- R9: A setting written while the block runs is adopted only when the current period completes. The high phase in progress is never shortened, and the first phase after the change is a full low phase of the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_en | input | 1 | Output enable. Low forces both outputs low without a clock edge |
| wr_en | input | 1 | One-cycle strobe that captures wr_oct and wr_mode as the pending setting |
| wr_oct | input | 4 | Octave code, 15 = fastest |
| wr_mode | input | 2 | Output mode code (00 pair, 01 auxiliary only, 10 main only, 11 sleep) |
| clk_main | output | 1 | Main divided clock |
| clk_aux | output | 1 | Auxiliary divided clock |

## Verification
Suppose the selected counter bit and the registered tap fall out of step, or a setting is adopted off a period boundary. The output then shows a phase whose length is not the selected half period. This appears within one output period, and the bench measures it as a wrong high or low count. A mode decode fault appears in the first measured period: an output that should be low is seen high, or the pair outputs are seen equal. A sleeping counter that was not held appears as a wake-up rise later than 10 cycles. A wrong reset value appears as a first low phase of the wrong length, 2^15 cycles after release.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

    // Output mode codes; the values are decoded by the output stage.
    typedef enum logic [1:0] {
        MODE_PAIR  = 2'b00,
        MODE_AUX   = 2'b01,
        MODE_MAIN  = 2'b10,
        MODE_SLEEP = 2'b11
    } mode_e;

endpackage

// File: rtl/ocd_setting_reg.sv
module ocd_setting_reg
    import ocd_pkg::*;
#(
    parameter int OCT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OCT_W-1:0] wr_oct,
    input  mode_e            wr_mode,
    input  logic             at_end,
    output logic [OCT_W-1:0] cur_oct,
    output mode_e            cur_mode,
    output logic             restart
);

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        mode_e            mode;
        logic             pend_v;
        logic [OCT_W-1:0] pend_oct;
        mode_e            pend_mode;
    } set_st_t;

    set_st_t s_d, s_q;
    logic    sleeping;

    always_comb begin
        s_d      = s_q;
        restart  = 1'b0;
        sleeping = (s_q.mode == MODE_SLEEP);
        // adopt the pending setting at a period boundary, or at once when asleep
        if (s_q.pend_v && (at_end || sleeping)) begin
            s_d.oct    = s_q.pend_oct;
            s_d.mode   = s_q.pend_mode;
            s_d.pend_v = 1'b0;
            restart    = 1'b1;
        end
        // a newer write replaces whatever is waiting
        if (wr_en) begin
            s_d.pend_v    = 1'b1;
            s_d.pend_oct  = wr_oct;
            s_d.pend_mode = wr_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_oct  = s_q.oct;
    assign cur_mode = s_q.mode;

    // R9: the active setting only moves after a boundary or while asleep
    p_apply_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({s_q.oct, s_q.mode}) |-> $past(at_end || sleeping));

endmodule

// File: rtl/ocd_divider.sv
module ocd_divider #(
    parameter int OCT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCT_W-1:0] oct,
    input  logic             restart,
    input  logic             hold,
    output logic             tap,
    output logic             at_end
);

    localparam int               CW      = 1 << OCT_W;
    localparam logic [OCT_W-1:0] TOP_IDX = OCT_W'(CW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tap;
    } div_st_t;

    div_st_t          s_d, s_q;
    logic [OCT_W-1:0] sel;
    logic [CW-1:0]    span;

    always_comb begin
        sel    = TOP_IDX - oct;
        span   = {CW{1'b1}} >> oct;          // bits 0..sel
        at_end = &(s_q.cnt | ~span);         // last cycle of a full period
        s_d    = s_q;
        if (restart || hold) begin
            s_d.cnt = '0;
            s_d.tap = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
            s_d.tap = s_d.cnt[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tap = s_q.tap;

    // R2: the registered tap always matches the selected counter bit
    p_tap_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tap == s_q.cnt[sel]);

    // R6: a sleeping counter stays at zero
    p_hold_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> (s_q.cnt == '0));

    // R9: a new setting starts from a clean low phase
    p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!s_q.tap && s_q.cnt == '0));

endmodule

// File: rtl/ocd_out_stage.sv
module ocd_out_stage
    import ocd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tap,
    input  mode_e mode,
    input  logic  out_en,
    output logic  clk_main,
    output logic  clk_aux
);

    typedef struct packed {
        logic main;
        logic aux;
    } out_st_t;

    out_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (mode)
            MODE_PAIR: begin
                s_d.main = tap;
                s_d.aux  = ~tap;
            end
            MODE_AUX: begin
                s_d.main = 1'b0;
                s_d.aux  = tap;
            end
            MODE_MAIN: begin
                s_d.main = tap;
                s_d.aux  = 1'b0;
            end
            default: begin
                s_d.main = 1'b0;
                s_d.aux  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.main <= 1'b0;
            s_q.aux  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // enable gating is combinational only, so a low enable acts without a clock
    assign clk_main = out_en & s_q.main;
    assign clk_aux  = out_en & s_q.aux;

    // R3: in pair mode the two registered outputs are always opposite
    p_pair_comp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_PAIR) |-> (s_q.aux == !s_q.main));

endmodule

// File: rtl/octave_clock_divider.sv
module octave_clock_divider
    import ocd_pkg::*;
#(
    parameter int OCT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             wr_en,
    input  logic [OCT_W-1:0] wr_oct,
    input  logic [1:0]       wr_mode,
    output logic             clk_main,
    output logic             clk_aux
);

    logic [OCT_W-1:0] cur_oct;
    mode_e            cur_mode;
    logic             restart;
    logic             at_end;
    logic             tap;
    logic             asleep;

    assign asleep = (cur_mode == MODE_SLEEP);

    ocd_setting_reg #(.OCT_W(OCT_W)) u_set (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_oct   (wr_oct),
        .wr_mode  (mode_e'(wr_mode)),
        .at_end   (at_end),
        .cur_oct  (cur_oct),
        .cur_mode (cur_mode),
        .restart  (restart)
    );

    ocd_divider #(.OCT_W(OCT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .oct     (cur_oct),
        .restart (restart),
        .hold    (asleep),
        .tap     (tap),
        .at_end  (at_end)
    );

    ocd_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap      (tap),
        .mode     (cur_mode),
        .out_en   (out_en),
        .clk_main (clk_main),
        .clk_aux  (clk_aux)
    );

    // R6: once asleep for a cycle, both pins are quiet
    p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep)) |-> (!clk_main && !clk_aux));

endmodule

// File: tb/octave_clock_divider_tb.sv
module octave_clock_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_oct = '0;
    logic [1:0] wr_mode = '0;
    logic       clk_main;
    logic       clk_aux;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  prev_period = 65536;

    always #4 clk = ~clk;   // 125 MHz

    octave_clock_divider u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .wr_en    (wr_en),
        .wr_oct   (wr_oct),
        .wr_mode  (wr_mode),
        .clk_main (clk_main),
        .clk_aux  (clk_aux)
    );

    function automatic int exp_half(input int o);
        return 1 << (15 - o);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic write_set(input int o, input int m);
        wr_oct  = 4'(o);
        wr_mode = 2'(m);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure one full high+low phase of the chosen output, tallying the other
    task automatic measure(input bit on_aux, output int hi, output int lo,
                           output int mism, output int other_hi);
        int   guard;
        logic prev, cur;
        hi = 0; lo = 0; mism = 0; other_hi = 0; guard = 0;
        prev = on_aux ? clk_aux : clk_main;
        while (guard < 70000) begin
            @(negedge clk);
            guard++;
            if (clk_aux == clk_main) mism++;
            if (on_aux ? clk_main : clk_aux) other_hi++;
            cur = on_aux ? clk_aux : clk_main;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        while (guard < 140000) begin
            @(negedge clk);
            guard++;
            if (clk_aux == clk_main) mism++;
            if (on_aux ? clk_main : clk_aux) other_hi++;
            cur = on_aux ? clk_aux : clk_main;
            if (!cur) break;
            hi++;
        end
        lo = 1;
        while (guard < 210000) begin
            @(negedge clk);
            guard++;
            if (clk_aux == clk_main) mism++;
            if (on_aux ? clk_main : clk_aux) other_hi++;
            cur = on_aux ? clk_aux : clk_main;
            if (cur) break;
            lo++;
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            summary();
            $finish;
        end
    end

    initial begin : main_flow
        int hi, lo, mism, oth, n, o, m;
        void'($urandom(32'd7713));

        // R8: reset state
        wait_cyc(3);
        check(clk_main == 1'b0, "R8 main low in reset", int'(clk_main), 0);
        check(clk_aux == 1'b1, "R8 aux high in reset", int'(clk_aux), 1);
        rst_n = 1'b1;

        // R8: first low phase at octave 0
        n = 0;
        @(negedge clk);
        while (!clk_main && n < 70000) begin
            n++;
            @(negedge clk);
        end
        check(n == 32768, "R8 first low phase", n, 32768);
        check(clk_aux == 1'b0, "R3 aux inverse at first rise", int'(clk_aux), 0);

        // R9: write during the high phase; the high phase must complete in full
        wr_oct = 4'd13; wr_mode = 2'b00; wr_en = 1'b1;
        hi = 1;
        while (hi < 70000) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!clk_main) break;
            hi++;
        end
        check(hi == 32768, "R9 old high phase kept", hi, 32768);
        lo = 1;
        while (lo < 70000) begin
            @(negedge clk);
            if (clk_main) break;
            lo++;
        end
        check(lo == exp_half(13), "R9 first new low phase", lo, exp_half(13));
        measure(1'b0, hi, lo, mism, oth);
        check(hi == exp_half(13), "R1 octave 13 high", hi, exp_half(13));
        check(lo == exp_half(13), "R2 octave 13 low", lo, exp_half(13));
        prev_period = 2 * exp_half(13);

        // random settings, modes 00/01/10
        for (int it = 0; it < 12; it++) begin
            o = 6 + int'($urandom % 10);
            m = int'($urandom % 3);
            write_set(o, m);
            wait_cyc(prev_period + 6);
            measure(m == 1, hi, lo, mism, oth);
            check(hi == exp_half(o), $sformatf("R1 oct %0d mode %0d high", o, m), hi, exp_half(o));
            check(lo == exp_half(o), $sformatf("R2 oct %0d mode %0d low", o, m), lo, exp_half(o));
            if (m == 0) check(mism == 0, "R3 pair outputs opposite", mism, 0);
            if (m == 1) check(oth == 0, "R4 main held low", oth, 0);
            if (m == 2) check(oth == 0, "R5 aux held low", oth, 0);
            prev_period = 2 * exp_half(o);
        end

        // fastest octave, main only
        write_set(15, 2);
        wait_cyc(prev_period + 6);
        measure(1'b0, hi, lo, mism, oth);
        check(hi == 1 && lo == 1, "R1 octave 15 period 2", hi + lo, 2);
        check(oth == 0, "R5 aux low at octave 15", oth, 0);
        prev_period = 2;

        // R6: sleep
        write_set(10, 3);
        wait_cyc(prev_period + 6);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_main || clk_aux) n++;
        end
        check(n == 0, "R6 outputs quiet asleep", n, 0);
        write_set(12, 0);
        n = 0;
        while (!clk_main && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == 10, "R6 wake latency", n, 10);
        measure(1'b0, hi, lo, mism, oth);
        check(hi == 8 && lo == 8, "R6 period after wake", hi + lo, 16);

        // R7: asynchronous force low
        while (!clk_aux) @(negedge clk);
        out_en = 1'b0;
        #1;
        check(!clk_aux && !clk_main, "R7 forced low without edge", int'(clk_aux | clk_main), 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_main || clk_aux) n++;
        end
        check(n == 0, "R7 held low while disabled", n, 0);
        out_en = 1'b1;
        #1;
        check((clk_main ^ clk_aux) == 1'b1, "R7 restored without edge", int'(clk_main ^ clk_aux), 1);
        measure(1'b0, hi, lo, mism, oth);
        check(hi == 8 && lo == 8, "R7 period unchanged", hi + lo, 16);

        // R9: faster switch 12 -> 14
        while (clk_main) @(negedge clk);
        while (!clk_main) @(negedge clk);
        wr_oct = 4'd14; wr_mode = 2'b00; wr_en = 1'b1;
        hi = 1;
        while (hi < 1000) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!clk_main) break;
            hi++;
        end
        check(hi == 8, "R9 high phase kept on speedup", hi, 8);
        lo = 1;
        while (lo < 1000) begin
            @(negedge clk);
            if (clk_main) break;
            lo++;
        end
        check(lo == 2, "R9 new low phase on speedup", lo, 2);
        measure(1'b0, hi, lo, mism, oth);
        check(hi == 2 && lo == 2, "R1 octave 14 period", hi + lo, 4);
        check(mism == 0, "R3 pair at octave 14", mism, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule